// File: doc/BRIEF.md
# Power-Fail Reset Sequencer

This block turns a digital power-good indication from a supply comparator into a system reset and a register write-protect. When the supply is reported bad, reset is pulled active and register writes are blocked. When the supply comes back, write-protect drops at once. Reset is held for a stabilization interval counted in timebase ticks: 8192 ticks of a 32.768 kHz timebase give 250 ms. The reset output is open drain. The block drives one enable that pulls the pad low, and with that enable off the pad is left floating.

If the oscillator-disable bit is set when the supply returns, the timebase oscillator was stopped during the outage. The sequencer then waits for an oscillator-ready indication before it starts counting the hold interval, so the total hold is the startup time plus the nominal interval. A cycle-count timeout bounds that wait so that reset can never hang. A new supply failure at any point sends the sequence back to the failed state. The count then starts again from nothing on the next return.

Top module: `pfr_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, the block is in the failed phase with `rstPullLow`=1 and `writeProtect`=1 until the supply has been reported good.
- R2: A low sample of `pwrGood` at a clock edge makes `writeProtect` and `rstPullLow` both 1 no later than the third following clock edge. The latency is SYNC_STAGES synchronizer flops plus one state register.
- R3: With `oscStopBit`=0 at power return and `tick` high every cycle, `rstPullLow` falls HOLD_TICKS+3 clock edges after the first good sample. The hold phase ends on its HOLD_TICKS-th `tick`.
- R4: With `oscStopBit`=1 at power return, hold counting starts only in the cycle after `oscReady` is seen high in the oscillator-wait phase. Ticks during the wait are not counted.
- R5: The oscillator wait lasts at most OSC_WAIT_CYCLES clock cycles. With `oscReady` never asserted and ticks every cycle, release comes OSC_WAIT_CYCLES+HOLD_TICKS+3 edges after the first good sample.
- R6: A low `pwrGood` during the wait or hold phase returns the block to the failed phase. The next return restarts the full sequence, so a return with `oscStopBit`=0 again releases after HOLD_TICKS+3 edges.
- R7: `writeProtect` is 1 exactly in the failed phase. It is 0 during the oscillator wait, the hold and run, and it never rises without `rstPullLow` also being 1.
- R8: `rstPullLow`=1 (pad pulled low) in every phase except run. 0 means the pad is released to high impedance.
- R9: `oscStopBit` is used only when the failed phase is left. Changing it during hold does not alter the release time.
- R10: `oscReady` has no effect outside the oscillator-wait phase. Pulsing it during hold does not shorten the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| pwrGood | input | 1 | Supply comparator output, 1 = supply above threshold (asynchronous) |
| tick | input | 1 | Timebase tick strobe, one clock wide |
| oscStopBit | input | 1 | Oscillator-disable control bit, 1 = oscillator was stopped during outage |
| oscReady | input | 1 | Oscillator running and stable |
| rstPullLow | output | 1 | Open-drain enable, 1 = pull reset pad low |
| writeProtect | output | 1 | 1 = block register writes |

## Verification
On every cycle, the checker ties the edges of `writeProtect` to the supply sample taken three edges earlier. It also checks that write-protect never appears without reset, and that the oscillator wait and the hold count stay inside their bounds. It confirms that a release happens only on the final hold tick, and that a ready seen during the wait moves the block straight into hold. The exact release latencies, the restart after a failure in mid-sequence, and the fact that the oscillator bit and the ready input are ignored outside their windows can only be shown by the bench's scenarios. In those scenarios a behavioural model is compared against the outputs on every clock.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  typedef enum logic [1:0] {
    PH_FAILED  = 2'd0,
    PH_OSCWAIT = 2'd1,
    PH_HOLD    = 2'd2,
    PH_RUN     = 2'd3
  } phase_e;

  typedef struct packed {
    logic clr;
    logic inc;
  } tmr_cmd_t;

  typedef struct packed {
    logic holdDone;
    logic waitDone;
  } tmr_sts_t;
endpackage

// File: rtl/pfr_sync.sv
module pfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dIn,
  output logic qOut
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= dIn;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign qOut = chain[STAGES-1];
endmodule

// File: rtl/pfr_timer.sv
module pfr_timer
  import pfr_pkg::*;
#(
  parameter int HOLD_TICKS      = 8192,
  parameter int OSC_WAIT_CYCLES = 65536
) (
  input  logic     clk,
  input  logic     rst_n,
  input  tmr_cmd_t cmd,
  output tmr_sts_t sts
);
  localparam int MAXV  = (HOLD_TICKS > OSC_WAIT_CYCLES) ? HOLD_TICKS : OSC_WAIT_CYCLES;
  localparam int CNT_W = $clog2(MAXV + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(OSC_WAIT_CYCLES - 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (cmd.clr) count <= '0;
    else if (cmd.inc) count <= count + CNT_W'(1);
  end

  assign sts.holdDone = (count == HOLD_LAST);
  assign sts.waitDone = (count == WAIT_LAST);
endmodule

// File: rtl/pfr_ctrl.sv
module pfr_ctrl
  import pfr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     goodSync,
  input  logic     tick,
  input  logic     oscStopBit,
  input  logic     oscReady,
  input  tmr_sts_t sts,
  output tmr_cmd_t cmd,
  output phase_e   phase,
  output logic     rstPullLow,
  output logic     writeProtect
);
  phase_e phaseNext;

  always_comb begin
    phaseNext = phase;
    cmd       = '0;
    unique case (phase)
      PH_FAILED: begin
        if (goodSync) begin
          cmd.clr   = 1'b1;
          phaseNext = oscStopBit ? PH_OSCWAIT : PH_HOLD;
        end
      end
      PH_OSCWAIT: begin
        if (!goodSync) begin
          phaseNext = PH_FAILED;
        end else if (oscReady || sts.waitDone) begin
          cmd.clr   = 1'b1;
          phaseNext = PH_HOLD;
        end else begin
          cmd.inc = 1'b1;
        end
      end
      PH_HOLD: begin
        if (!goodSync) begin
          phaseNext = PH_FAILED;
        end else if (tick) begin
          if (sts.holdDone) phaseNext = PH_RUN;
          else              cmd.inc   = 1'b1;
        end
      end
      PH_RUN: begin
        if (!goodSync) phaseNext = PH_FAILED;
      end
      default: phaseNext = PH_FAILED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_FAILED;
    else        phase <= phaseNext;
  end

  assign rstPullLow   = (phase != PH_RUN);
  assign writeProtect = (phase == PH_FAILED);
endmodule

// File: rtl/pfr_seq.sv
module pfr_seq
  import pfr_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int HOLD_TICKS      = 8192,
  parameter int OSC_WAIT_CYCLES = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrGood,
  input  logic tick,
  input  logic oscStopBit,
  input  logic oscReady,
  output logic rstPullLow,
  output logic writeProtect
);
  logic     goodSync;
  tmr_cmd_t tmrCmd;
  tmr_sts_t tmrSts;
  phase_e   phase;

  pfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .dIn   (pwrGood),
    .qOut  (goodSync)
  );

  pfr_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .goodSync     (goodSync),
    .tick         (tick),
    .oscStopBit   (oscStopBit),
    .oscReady     (oscReady),
    .sts          (tmrSts),
    .cmd          (tmrCmd),
    .phase        (phase),
    .rstPullLow   (rstPullLow),
    .writeProtect (writeProtect)
  );

  pfr_timer #(
    .HOLD_TICKS      (HOLD_TICKS),
    .OSC_WAIT_CYCLES (OSC_WAIT_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (tmrCmd),
    .sts   (tmrSts)
  );
endmodule

// File: rtl/pfr_seq_chk.sv
module pfr_seq_chk
  import pfr_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int HOLD_TICKS      = 8192,
  parameter int OSC_WAIT_CYCLES = 65536
) (
  input logic   clk,
  input logic   rst_n,
  input logic   pwrGood,
  input logic   tick,
  input logic   oscReady,
  input logic   rstPullLow,
  input logic   writeProtect,
  input phase_e phase
);
  localparam int LAT = SYNC_STAGES + 1;

  int waitLen;
  int holdTicks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waitLen   <= 0;
      holdTicks <= 0;
    end else begin
      waitLen   <= (phase == PH_OSCWAIT) ? waitLen + 1 : 0;
      if (phase != PH_HOLD) holdTicks <= 0;
      else if (tick)        holdTicks <= holdTicks + 1;
    end
  end

  // R7
  wp_implies_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    writeProtect |-> rstPullLow);

  // R2
  fail_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwrGood, LAT) |-> (writeProtect && rstPullLow));

  // R6
  wp_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(writeProtect) |-> !$past(pwrGood, LAT));

  // R7
  wp_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(writeProtect) |-> $past(pwrGood, LAT));

  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OSCWAIT) |-> (waitLen < OSC_WAIT_CYCLES));

  // R3
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |-> (holdTicks < HOLD_TICKS));

  // R3
  release_on_last_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rstPullLow) |-> ($past(tick) && ($past(holdTicks) == HOLD_TICKS - 1)));

  // R4
  ready_enters_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_OSCWAIT) && oscReady && $past(pwrGood, SYNC_STAGES)) |=> (phase == PH_HOLD));
endmodule

bind pfr_seq pfr_seq_chk #(
  .SYNC_STAGES     (SYNC_STAGES),
  .HOLD_TICKS      (HOLD_TICKS),
  .OSC_WAIT_CYCLES (OSC_WAIT_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwrGood      (pwrGood),
  .tick         (tick),
  .oscReady     (oscReady),
  .rstPullLow   (rstPullLow),
  .writeProtect (writeProtect),
  .phase        (phase)
);

// File: tb/sim_pfr_seq.sv
`timescale 1ns/1ps
module sim_pfr_seq;
  localparam int H = 20;
  localparam int T = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrGood = 1'b0;
  logic tick = 1'b0;
  logic oscStopBit = 1'b0;
  logic oscReady = 1'b0;
  logic rstPullLow;
  logic writeProtect;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tickEvery = 1;
  int tickPh = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfr_seq #(.SYNC_STAGES(2), .HOLD_TICKS(H), .OSC_WAIT_CYCLES(T)) u0 (
    .clk(clk), .rst_n(rst_n), .pwrGood(pwrGood), .tick(tick),
    .oscStopBit(oscStopBit), .oscReady(oscReady),
    .rstPullLow(rstPullLow), .writeProtect(writeProtect)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic chkInt(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: 0 failed, 1 osc wait, 2 hold, 3 run
  int mPhase = 0;
  int mCnt = 0;
  bit goodQ[$] = '{0, 0};
  bit mGood;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mPhase = 0;
      mCnt = 0;
      goodQ = '{0, 0};
    end else begin
      mGood = goodQ.pop_front();
      goodQ.push_back(pwrGood);
      case (mPhase)
        0: if (mGood) begin mCnt = 0; mPhase = oscStopBit ? 1 : 2; end
        1: if (!mGood) mPhase = 0;
           else if (oscReady || mCnt == T - 1) begin mPhase = 2; mCnt = 0; end
           else mCnt++;
        2: if (!mGood) mPhase = 0;
           else if (tick) begin mCnt++; if (mCnt == H) mPhase = 3; end
        default: if (!mGood) mPhase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    tickPh++;
    tick = ((tickPh % tickEvery) == 0);
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      case (mPhase)
        0: begin chk("R7 failed-phase wp", writeProtect, 1'b1); chk("R8 failed-phase rst", rstPullLow, 1'b1); end
        1: begin chk("R4 wait-phase wp", writeProtect, 1'b0); chk("R4 wait-phase rst", rstPullLow, 1'b1); end
        2: begin chk("R3 hold-phase wp", writeProtect, 1'b0); chk("R3 hold-phase rst", rstPullLow, 1'b1); end
        default: begin chk("R8 run-phase wp", writeProtect, 1'b0); chk("R8 run-phase rst", rstPullLow, 1'b0); end
      endcase
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic countUntilRelease(inout int n);
    while (rstPullLow === 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic failSupply();
    int n;
    n = 0;
    pwrGood = 1'b0;
    while (writeProtect !== 1'b1 && n < 50) begin
      @(negedge clk);
      n++;
    end
    chkInt("R2 fail latency edges", n, 3);
    chk("R8 reset pulled on fail", rstPullLow, 1'b1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int n;
    // R1 reset state
    repeat (5) @(negedge clk);
    chk("R1 wp in reset", writeProtect, 1'b1);
    chk("R1 rst in reset", rstPullLow, 1'b1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 wp after reset", writeProtect, 1'b1);
    chk("R1 rst after reset", rstPullLow, 1'b1);

    // R3 plain power-up hold
    oscStopBit = 1'b0;
    pwrGood = 1'b1;
    n = 0;
    countUntilRelease(n);
    chkInt("R3 hold release edges", n, H + 3);
    repeat (5) @(negedge clk);

    // R5 oscillator wait with timeout
    failSupply();
    oscStopBit = 1'b1;
    pwrGood = 1'b1;
    n = 0;
    countUntilRelease(n);
    chkInt("R5 timeout release edges", n, T + H + 3);
    repeat (3) @(negedge clk);

    // R4 oscillator ready ends the wait
    failSupply();
    oscStopBit = 1'b1;
    pwrGood = 1'b1;
    n = 0;
    repeat (6) begin @(negedge clk); n++; end
    chk("R7 wp low in osc wait", writeProtect, 1'b0);
    chk("R4 rst held in osc wait", rstPullLow, 1'b1);
    oscReady = 1'b1;
    @(negedge clk); n++;
    oscReady = 1'b0;
    countUntilRelease(n);
    chkInt("R4 ready release edges", n, H + 7);

    // R6 failure in hold restarts the sequence
    failSupply();
    oscStopBit = 1'b0;
    pwrGood = 1'b1;
    repeat (10) @(negedge clk);
    pwrGood = 1'b0;
    @(negedge clk);
    pwrGood = 1'b1;
    n = 0;
    countUntilRelease(n);
    chkInt("R6 restart release edges", n, H + 3);

    // R6 failure during osc wait
    failSupply();
    oscStopBit = 1'b1;
    pwrGood = 1'b1;
    repeat (5) @(negedge clk);
    pwrGood = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 wait back to failed", writeProtect, 1'b1);
    oscStopBit = 1'b0;
    pwrGood = 1'b1;
    n = 0;
    countUntilRelease(n);
    chkInt("R6 wait restart release edges", n, H + 3);

    // R9 and R10: bit change and ready pulse during hold have no effect
    failSupply();
    oscStopBit = 1'b0;
    pwrGood = 1'b1;
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    oscStopBit = 1'b1;
    oscReady = 1'b1;
    repeat (3) begin @(negedge clk); n++; end
    oscReady = 1'b0;
    countUntilRelease(n);
    chkInt("R9 R10 hold unaffected release edges", n, H + 3);
    oscStopBit = 1'b0;

    // Slow ticks and random supply activity, model compared every cycle
    tickEvery = 3;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (($urandom % 97) == 0) pwrGood = ~pwrGood;
      if (($urandom % 13) == 0) oscStopBit = $urandom % 2;
      oscReady = (($urandom % 29) == 0);
    end
    pwrGood = 1'b1;
    oscReady = 1'b0;
    repeat (3 * H + T + 20) @(negedge clk);
    chk("R3 slow-tick final release", rstPullLow, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule